// File: doc/BRIEF.md
# Glitch-Free Clock Select and Gate

This block chooses between two clock sources: a fast system clock and a slower scan or test clock. A select input makes the choice. The chosen clock is gated by one active-low enable and then copied to a set of identical clock outputs, five by default. The enable is not applied directly. It is captured by a register that is clocked on the falling edge of the chosen clock. Because the gate sits after the source mux, an output can only start or stop toggling while it is already low. No shortened high pulse ever reaches an output.

Typical use is a clock-root leaf. Functional logic runs from the system clock. A test controller stops the clocks, moves the select over to the scan clock and starts them again. Every downstream region receives the same clean pulses. Changing the select while the outputs are enabled is outside the guarantee, so the select is only changed while the outputs are disabled.

Top module: `clk_sel_gate`

## Requirements
- R1: A select value of 0 routes the system clock. This is the default source.
- R2: A select value of 1 routes the scan clock, and the system clock then has no effect on the outputs.
- R3: While the registered enable is active, each output is high for exactly the full high phase of the selected clock and low for its low phase.
- R4: When the enable input is 1 (inactive), the outputs are forced to 0 starting at the next falling edge of the selected clock.
- R5: The enable is captured only on the falling edge of the selected clock. A change while the clock is high never shortens the current high phase. A change while the clock is low does not affect the next high phase.
- R6: When the enable input goes to 0 during a high phase, that high phase stays at 0 on the outputs. Output pulses begin with the first full high phase after the next falling edge.
- R7: Reset is synchronous and active high, and is sampled on the falling edge of the selected clock. It puts the enable register in the disabled state. The outputs stay low until a falling edge, with reset released, captures an enable input of 0.
- R8: All NUM_OUT outputs carry the same value at all times.
- R9: Changing the select while the outputs are disabled leaves every output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys_i | input | 1 | System clock source |
| clk_scan_i | input | 1 | Scan or test clock source |
| src_sel_i | input | 1 | Source select: 0 system, 1 scan |
| gate_n_i | input | 1 | Active-low enable, captured on the falling edge of the selected clock |
| rst_i | input | 1 | Synchronous active-high reset |
| clk_o | output | NUM_OUT | Gated copies of the selected clock |

## Verification
The bench builds the block with NUM_OUT at its default of 5. This value covers a fan-out that is wider than one lane, so any lane that departs from the others shows up in the all-lanes comparisons. The system clock period is 20 ns and the scan clock period is 70 ns. Measured pulse widths therefore show which source is routed, and the 35 ns and 10 ns high phases separate full pulses from shortened ones. The enable is toggled in both the high and the low phase of each source. This places the capture edge just before and just after each change.

// File: rtl/cksg_pkg.sv
package cksg_pkg;

    // Default number of gated clock lanes
    localparam int unsigned LANES_DEF = 5;

    // Source selection encoding: 0 = system clock, 1 = scan clock
    typedef enum logic {
        SRC_SYS  = 1'b0,
        SRC_SCAN = 1'b1
    } src_sel_e;

    // The two candidate clock sources, carried together
    typedef struct packed {
        logic sys;
        logic scan;
    } clk_pair_t;

    // Returns the source picked by a given selection
    function automatic logic pick_src(clk_pair_t pair, src_sel_e sel);
        return (sel == SRC_SCAN) ? pair.scan : pair.sys;
    endfunction

endpackage

// File: rtl/cksg_src_mux.sv
module cksg_src_mux
    import cksg_pkg::*;
(
    input  clk_pair_t srcs_i,
    input  src_sel_e  sel_i,
    output logic      clk_o
);

    // Plain combinational source select; the gate downstream hides its switching
    always_comb begin
        clk_o = pick_src(srcs_i, sel_i);
    end

endmodule

// File: rtl/cksg_en_reg.sv
module cksg_en_reg (
    input  logic clk_i,
    input  logic rst_i,
    input  logic gate_n_i,
    output logic en_o
);

    // Captured on the falling edge, so the gate only moves while the clock is low
    always_ff @(negedge clk_i) begin
        if (rst_i) begin
            en_o <= 1'b0;
        end else begin
            en_o <= ~gate_n_i;
        end
    end

endmodule

// File: rtl/cksg_fanout.sv
module cksg_fanout #(
    parameter int unsigned NUM_OUT = 5
) (
    input  logic               clk_i,
    input  logic               en_i,
    output logic [NUM_OUT-1:0] clk_o
);

    // One gate per lane so each output has its own driver
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
        assign clk_o[g] = clk_i & en_i;
    end

endmodule

// File: rtl/clk_sel_gate.sv
module clk_sel_gate
    import cksg_pkg::*;
#(
    parameter int unsigned NUM_OUT = LANES_DEF
) (
    input  logic               clk_sys_i,
    input  logic               clk_scan_i,
    input  logic               src_sel_i,
    input  logic               gate_n_i,
    input  logic               rst_i,
    output logic [NUM_OUT-1:0] clk_o
);

    clk_pair_t srcs;
    src_sel_e  sel;
    logic      clk_mux;
    logic      en_live;

    assign srcs.sys  = clk_sys_i;
    assign srcs.scan = clk_scan_i;
    assign sel       = src_sel_e'(src_sel_i);

    cksg_src_mux u_mux (
        .srcs_i (srcs),
        .sel_i  (sel),
        .clk_o  (clk_mux)
    );

    cksg_en_reg u_en (
        .clk_i    (clk_mux),
        .rst_i    (rst_i),
        .gate_n_i (gate_n_i),
        .en_o     (en_live)
    );

    cksg_fanout #(
        .NUM_OUT (NUM_OUT)
    ) u_fan (
        .clk_i (clk_mux),
        .en_i  (en_live),
        .clk_o (clk_o)
    );

endmodule

// File: rtl/clk_sel_gate_chk.sv
module clk_sel_gate_chk #(
    parameter int unsigned NUM_OUT = 5
) (
    input logic               clk_sys_i,
    input logic               clk_scan_i,
    input logic               src_sel_i,
    input logic               rst_i,
    input logic               en_q,
    input logic [NUM_OUT-1:0] clk_o
);

    logic en_at_rise;
    logic seen_rise;

    // Records the enable state at each system rising edge
    always_ff @(posedge clk_sys_i) begin
        if (rst_i) begin
            seen_rise  <= 1'b0;
            en_at_rise <= 1'b0;
        end else begin
            seen_rise  <= 1'b1;
            en_at_rise <= en_q;
        end
    end

    // R1 R3: an enabled system-clock high phase reaches every lane
    a_r3_sys_full_high: assert property (@(negedge clk_sys_i) disable iff (rst_i)
        (!src_sel_i && en_q) |-> (clk_o == {NUM_OUT{1'b1}}));

    // R2 R3: an enabled scan-clock high phase reaches every lane
    a_r2_scan_full_high: assert property (@(negedge clk_scan_i) disable iff (rst_i)
        (src_sel_i && en_q) |-> (clk_o == {NUM_OUT{1'b1}}));

    // R4: a disabled gate holds the lanes low through the high phase
    a_r4_off_is_low: assert property (@(negedge clk_sys_i) disable iff (rst_i)
        (!src_sel_i && !en_q) |-> (clk_o == '0));

    // R5: the gate state never moves during a system-clock high phase
    a_r5_no_change_high: assert property (@(negedge clk_sys_i) disable iff (rst_i)
        (!src_sel_i && seen_rise) |-> (en_q == en_at_rise));

    // R8: all lanes agree
    a_r8_lanes_match: assert property (@(negedge clk_sys_i) disable iff (rst_i)
        (clk_o == {NUM_OUT{clk_o[0]}}));

endmodule

bind clk_sel_gate clk_sel_gate_chk #(
    .NUM_OUT (NUM_OUT)
) u_chk (
    .clk_sys_i  (clk_sys_i),
    .clk_scan_i (clk_scan_i),
    .src_sel_i  (src_sel_i),
    .rst_i      (rst_i),
    .en_q       (en_live),
    .clk_o      (clk_o)
);

// File: tb/test_clk_sel_gate.sv
`timescale 1ns/1ps
module test_clk_sel_gate;

    localparam int unsigned N = 5;
    localparam logic [N-1:0] ONES = {N{1'b1}};

    logic         clk_sys;
    logic         clk_scan;
    logic         sel;
    logic         gate_n;
    logic         rst;
    logic [N-1:0] clk_o;

    int n_checks;
    int n_fails;

    clk_sel_gate #(.NUM_OUT(N)) i_clk_sel_gate (
        .clk_sys_i  (clk_sys),
        .clk_scan_i (clk_scan),
        .src_sel_i  (sel),
        .gate_n_i   (gate_n),
        .rst_i      (rst),
        .clk_o      (clk_o)
    );

    // 50 MHz system clock, 70 ns scan clock
    initial begin
        clk_sys = 1'b0;
        forever #10 clk_sys = ~clk_sys;
    end
    initial begin
        clk_scan = 1'b0;
        forever #35 clk_scan = ~clk_scan;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic sys_mid_high();
        @(posedge clk_sys); #5;
    endtask
    task automatic sys_mid_low();
        @(negedge clk_sys); #5;
    endtask
    task automatic scan_mid_high();
        @(posedge clk_scan); #17;
    endtask

    task automatic expect_out(input logic [N-1:0] exp, input string req);
        check(clk_o === exp, req, int'(clk_o), int'(exp));
    endtask

    task automatic measure_pulse(input int exp_ns, input string req);
        realtime t0, t1;
        @(posedge clk_o[0]); t0 = $realtime;
        @(negedge clk_o[0]); t1 = $realtime;
        check(int'(t1 - t0) == exp_ns, req, int'(t1 - t0), exp_ns);
    endtask

    // R7: outputs low in reset and until a falling edge sees enable after release
    task automatic t_reset();
        rst = 1'b1; gate_n = 1'b0; sel = 1'b0;
        repeat (3) sys_mid_high();
        expect_out('0, "R7 low during reset");
        rst = 1'b0;
        #2 expect_out('0, "R7 low right after release");
        sys_mid_high();
        expect_out(ONES, "R7 R8 enabled after falling edge");
    endtask

    // R1 R3: system pulses are full 10 ns high phases
    task automatic t_sys_pulses();
        for (int i = 0; i < 3; i++) measure_pulse(10, "R1 R3 sys high width");
        sys_mid_low();
        expect_out('0, "R3 low phase low");
    endtask

    // R4 R5: disable in a high phase does not cut the pulse
    task automatic t_disable_sys();
        sys_mid_high();
        gate_n = 1'b1;
        #3 expect_out(ONES, "R5 current high phase kept");
        sys_mid_high();
        expect_out('0, "R4 off after falling edge");
        sys_mid_high();
        expect_out('0, "R4 stays off");
    endtask

    // R6: enable in a high phase starts at the next full pulse
    task automatic t_enable_high();
        sys_mid_high();
        gate_n = 1'b0;
        #2 expect_out('0, "R6 no partial pulse");
        sys_mid_high();
        expect_out(ONES, "R6 full pulse after falling edge");
    endtask

    // R5: a change in the low phase waits for the next falling edge
    task automatic t_enable_low();
        sys_mid_high(); gate_n = 1'b1;
        sys_mid_high();
        sys_mid_low(); gate_n = 1'b0;
        sys_mid_high();
        expect_out('0, "R5 low-phase change not yet active");
        sys_mid_high();
        expect_out(ONES, "R5 active after falling edge");
    endtask

    // R9 R2 R3: move to scan while disabled, then run scan pulses
    task automatic t_scan();
        sys_mid_high(); gate_n = 1'b1;
        sys_mid_high(); sys_mid_high();
        sel = 1'b1;
        scan_mid_high();
        expect_out('0, "R9 select change keeps outputs low");
        scan_mid_high();
        gate_n = 1'b0;
        #2 expect_out('0, "R6 scan no partial pulse");
        scan_mid_high();
        expect_out(ONES, "R2 scan pulse present");
        @(negedge clk_scan);
        @(posedge clk_sys); #5;
        expect_out('0, "R2 system clock ignored");
        measure_pulse(35, "R2 R3 scan high width");
        scan_mid_high();
        gate_n = 1'b1;
        #10 expect_out(ONES, "R5 scan high phase kept");
        scan_mid_high();
        expect_out('0, "R4 scan off after falling edge");
    endtask

    // R9 R1: back to the system clock while disabled
    task automatic t_back_to_sys();
        sel = 1'b0;
        sys_mid_high();
        expect_out('0, "R9 still low after return");
        gate_n = 1'b0;
        sys_mid_high();
        expect_out(ONES, "R1 system pulse again");
        measure_pulse(10, "R1 R3 sys width again");
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        n_checks = 0;
        n_fails  = 0;
        t_reset();
        t_sys_pulses();
        t_disable_sys();
        t_enable_high();
        t_enable_low();
        t_scan();
        t_back_to_sys();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule